// File: doc/BRIEF.md
# Bidirectional Auxiliary Mailbox with Maskable Interrupt

The block holds one 32-bit word in each direction between a console-side register bus and a controller-side register port. When the controller writes a word, the block keeps it for the console and raises a "mailbox not empty" pending flag on the console side. That flag reaches the console interrupt line only while its enable bit is set. When the console writes a word, it sends the word as two 16-bit halves, upper half first. Writing the lower half completes the word and sends a one-cycle notice to the controller side, which keeps it as a sticky flag.

There is no flow control. Each new write replaces the word stored before it, so software uses the mailbox as a ping-pong channel: one side writes, the other side answers. The console side sees the pending flag, can clear it, and can enable or disable the interrupt. Other interrupt sources enter through a small vector and are merged into the same registered interrupt output. Console register access is gated by an unlock input. A lock, a console NMI reset or a hard reset clears the console-side pending flag and the enable bit.

Top module: `aux_mailbox`

## Requirements
- R1: A controller write with `ctl_sel_i`=1 stores all 32 bits of `ctl_wdata_i`. The console reads the upper half at index 4 and the lower half at index 5. If access is unlocked and no NMI is active, the same edge sets the console pending flag.
- R2: The console pending flag reads at bit 26 of the status word, which is bit 10 of index 0. Writing 1 to bit 28 of the interrupt control word (bit 12 of index 2) clears it.
- R3: Writing 1 to bit 8 of the interrupt control word (index 3, bit 8) enables the interrupt. Writing 1 to bit 9 disables it. The enable reads back at bit 20 (index 2, bit 4). When bits 8 and 9 are both 1 in one write, the enable is set.
- R4: `irq_o` is high one cycle after (pending AND enable) OR any bit of `ext_irq_i` is high while access is unlocked, and low one cycle after that term is false.
- R5: A console write to index 4 stores the upper 16 bits of the console word. A write to index 5 stores the lower 16 bits and sends a one-cycle notice to the controller side. Writing index 4 alone sends no notice.
- R6: The controller sticky flag rises one cycle after the notice and reads at bit 12 of `ctl_rdata_o` when `ctl_sel_i`=0. A controller write with `ctl_sel_i`=0 and bit 13 set clears it. With `ctl_sel_i`=1, `ctl_rdata_o` returns the console word.
- R7: There is no flow control. A second write in either direction replaces the stored word completely.
- R8: While `unlock_i` is low or `nmi_i` is high, the next edge clears the pending flag and the enable. Console writes are ignored, controller writes do not set the pending flag, and `irq_o` goes low.
- R9: If a set event and a clear write arrive on the same edge, the flag ends up set. This applies to both the console pending flag and the controller sticky flag.
- R10: After hard reset, `irq_o` is 0, both flags and the enable read 0, and both stored words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| unlock_i | input | 1 | Console register access enabled |
| nmi_i | input | 1 | Console NMI reset, clears console-side state |
| con_wr_i | input | 1 | Console half-word write strobe |
| con_addr_i | input | 3 | Console register index: 0/1 status halves, 2/3 interrupt control halves, 4/5 data halves |
| con_wdata_i | input | 16 | Console write half-word |
| con_rdata_o | output | 16 | Console read half-word at `con_addr_i` |
| ctl_wr_i | input | 1 | Controller write strobe |
| ctl_sel_i | input | 1 | Controller select: 0 command-status word, 1 mailbox data |
| ctl_wdata_i | input | 32 | Controller write word |
| ctl_rdata_o | output | 32 | Controller read word at `ctl_sel_i` |
| ext_irq_i | input | EXT_IRQ_N | Other console interrupt sources, merged into `irq_o` |
| irq_o | output | 1 | Registered console interrupt |

## Verification
The bench builds the block with its default of two external interrupt sources. It drives each source separately to show that the merge does not depend on the mailbox enable, and it checks that the lock still silences both sources. Because the console bus is 16 bits wide, the same parameters let the bench test the two-step console word: a write to the upper half alone must not notify the controller. The bench also forces same-edge races between set and clear events on both flags.

// File: rtl/aux_mbox_pkg.sv
package aux_mbox_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    CR_STAT_H = 3'd0,
    CR_STAT_L = 3'd1,
    CR_IRQ_H  = 3'd2,
    CR_IRQ_L  = 3'd3,
    CR_DATA_H = 3'd4,
    CR_DATA_L = 3'd5
  } con_reg_e;

  // word-level bit positions seen by software
  localparam int PEND_RD_BIT = 26;
  localparam int PEND_CLR_BIT = 28;
  localparam int EN_RD_BIT = 20;
  localparam int EN_SET_BIT = 8;
  localparam int EN_CLR_BIT = 9;
  localparam int CTL_FLAG_BIT = 12;
  localparam int CTL_CLR_BIT = 13;

  // positions inside the upper half-word
  localparam int PEND_RD_H = PEND_RD_BIT - HALF_W;
  localparam int PEND_CLR_H = PEND_CLR_BIT - HALF_W;
  localparam int EN_RD_H = EN_RD_BIT - HALF_W;
endpackage

// File: rtl/aux_con_regs.sv
module aux_con_regs
  import aux_mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              unlock_i,
  input  logic              nmi_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic              set_i,
  input  logic [WORD_W-1:0] set_word_i,
  output logic [WORD_W-1:0] con_word_o,
  output logic              push_o,
  output logic              pend_o,
  output logic              en_o
);
  logic              hold;
  logic              wr_ok;
  con_reg_e          reg_sel;
  logic              pend_q, en_q, push_q;
  logic [WORD_W-1:0] mbox_q;
  logic [WORD_W-1:0] con_q;

  assign reg_sel = con_reg_e'(addr_i);
  assign hold    = !unlock_i || nmi_i;
  assign wr_ok   = wr_i && !hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      push_q <= 1'b0;
      mbox_q <= '0;
      con_q  <= '0;
    end else begin
      push_q <= wr_ok && (reg_sel == CR_DATA_L);
      if (wr_ok && reg_sel == CR_DATA_H) con_q[WORD_W-1:HALF_W] <= wdata_i;
      if (wr_ok && reg_sel == CR_DATA_L) con_q[HALF_W-1:0] <= wdata_i;
      if (set_i) mbox_q <= set_word_i;
      if (hold) begin
        pend_q <= 1'b0;
        en_q   <= 1'b0;
      end else begin
        // set beats clear
        if (set_i) pend_q <= 1'b1;
        else if (wr_ok && reg_sel == CR_IRQ_H && wdata_i[PEND_CLR_H]) pend_q <= 1'b0;
        // enable beats disable
        if (wr_ok && reg_sel == CR_IRQ_L) begin
          if (wdata_i[EN_SET_BIT]) en_q <= 1'b1;
          else if (wdata_i[EN_CLR_BIT]) en_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_sel)
      CR_STAT_H: rdata_o[PEND_RD_H] = pend_q;
      CR_IRQ_H:  rdata_o[EN_RD_H] = en_q;
      CR_DATA_H: rdata_o = mbox_q[WORD_W-1:HALF_W];
      CR_DATA_L: rdata_o = mbox_q[HALF_W-1:0];
      default:   rdata_o = '0;
    endcase
  end

  assign con_word_o = con_q;
  assign push_o     = push_q;
  assign pend_o     = pend_q;
  assign en_o       = en_q;

  assert_hold_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlock_i || nmi_i) |=> (!pend_q && !en_q));
  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && unlock_i && !nmi_i) |=> pend_q);
  assert_en_priority_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && unlock_i && !nmi_i && addr_i == 3'd3 && wdata_i[EN_SET_BIT]) |=> en_q);
  assert_push_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd4) |=> !push_q);
endmodule

// File: rtl/aux_ctl_regs.sv
module aux_ctl_regs
  import aux_mbox_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              push_i,
  input  logic [WORD_W-1:0] con_word_i,
  output logic              set_o,
  output logic [WORD_W-1:0] set_word_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (push_i) flag_q <= 1'b1;
    else if (wr_i && !sel_i && wdata_i[CTL_CLR_BIT]) flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) rdata_o = con_word_i;
    else rdata_o[CTL_FLAG_BIT] = flag_q;
  end

  assign set_o      = wr_i && sel_i;
  assign set_word_o = wdata_i;

  assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> flag_q);
  assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i && wdata_i[CTL_CLR_BIT] && !push_i) |=> !flag_q);
endmodule

// File: rtl/aux_irq_merge.sv
module aux_irq_merge #(
  parameter int EXT_IRQ_N = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 unlock_i,
  input  logic                 pend_i,
  input  logic                 en_i,
  input  logic [EXT_IRQ_N-1:0] ext_irq_i,
  output logic                 irq_o
);
  logic [EXT_IRQ_N:0] chain;
  logic               irq_q;

  assign chain[0] = pend_i && en_i;
  for (genvar g = 0; g < EXT_IRQ_N; g++) begin : g_or
    assign chain[g+1] = chain[g] || ext_irq_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= unlock_i && chain[EXT_IRQ_N];
  end

  assign irq_o = irq_q;

  assert_locked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_i |=> !irq_o);
  assert_irq_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_i && pend_i && en_i) |=> irq_o);
  assert_irq_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && ext_irq_i == '0) |=> !irq_o);
endmodule

// File: rtl/aux_mailbox.sv
module aux_mailbox
  import aux_mbox_pkg::*;
#(
  parameter int EXT_IRQ_N = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 unlock_i,
  input  logic                 nmi_i,
  input  logic                 con_wr_i,
  input  logic [2:0]           con_addr_i,
  input  logic [15:0]          con_wdata_i,
  output logic [15:0]          con_rdata_o,
  input  logic                 ctl_wr_i,
  input  logic                 ctl_sel_i,
  input  logic [31:0]          ctl_wdata_i,
  output logic [31:0]          ctl_rdata_o,
  input  logic [EXT_IRQ_N-1:0] ext_irq_i,
  output logic                 irq_o
);
  logic              set_w, push_w, pend_w, en_w;
  logic [WORD_W-1:0] set_word_w, con_word_w;

  aux_con_regs u_con (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .unlock_i   (unlock_i),
    .nmi_i      (nmi_i),
    .wr_i       (con_wr_i),
    .addr_i     (con_addr_i),
    .wdata_i    (con_wdata_i),
    .rdata_o    (con_rdata_o),
    .set_i      (set_w),
    .set_word_i (set_word_w),
    .con_word_o (con_word_w),
    .push_o     (push_w),
    .pend_o     (pend_w),
    .en_o       (en_w)
  );

  aux_ctl_regs u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (ctl_wr_i),
    .sel_i      (ctl_sel_i),
    .wdata_i    (ctl_wdata_i),
    .rdata_o    (ctl_rdata_o),
    .push_i     (push_w),
    .con_word_i (con_word_w),
    .set_o      (set_w),
    .set_word_o (set_word_w)
  );

  aux_irq_merge #(.EXT_IRQ_N(EXT_IRQ_N)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unlock_i  (unlock_i),
    .pend_i    (pend_w),
    .en_i      (en_w),
    .ext_irq_i (ext_irq_i),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/aux_mailbox_test.sv
module aux_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unlock = 1'b0, nmi = 1'b0;
  logic        con_wr = 1'b0;
  logic [2:0]  con_addr = 3'd0;
  logic [15:0] con_wdata = '0, con_rdata;
  logic        ctl_wr = 1'b0, ctl_sel = 1'b0;
  logic [31:0] ctl_wdata = '0, ctl_rdata;
  logic [1:0]  ext = '0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  aux_mailbox #(.EXT_IRQ_N(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .unlock_i(unlock), .nmi_i(nmi),
    .con_wr_i(con_wr), .con_addr_i(con_addr), .con_wdata_i(con_wdata),
    .con_rdata_o(con_rdata), .ctl_wr_i(ctl_wr), .ctl_sel_i(ctl_sel),
    .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata), .ext_irq_i(ext),
    .irq_o(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic con_write(logic [2:0] a, logic [15:0] d);
    @(negedge clk); con_wr = 1; con_addr = a; con_wdata = d;
    @(negedge clk); con_wr = 0; con_wdata = '0;
  endtask

  task automatic ctl_write(logic s, logic [31:0] d);
    @(negedge clk); ctl_wr = 1; ctl_sel = s; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0; ctl_wdata = '0;
  endtask

  task automatic con_read(logic [2:0] a, output logic [15:0] d);
    con_addr = a; #1 d = con_rdata;
  endtask

  task automatic ctl_read(logic s, output logic [31:0] d);
    ctl_sel = s; #1 d = ctl_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] h; logic [31:0] w;
    check("R10 irq", irq, 0);
    con_read(0, h); check("R10 pend", h, 0);
    con_read(2, h); check("R10 en", h, 0);
    con_read(4, h); check("R10 mbox", h, 0);
    ctl_read(0, w); check("R10 flag", w, 0);
    ctl_read(1, w); check("R10 con word", w, 0);
  endtask

  task automatic t_ctl_to_con;
    logic [15:0] h;
    ctl_write(1, 32'hA5C3_1E7F);
    con_read(4, h); check("R1 data hi", h, 16'hA5C3);
    con_read(5, h); check("R1 data lo", h, 16'h1E7F);
    con_read(0, h); check("R2 pend bit26", h, 16'h0400);
    @(negedge clk); check("R4 masked irq", irq, 0);
  endtask

  task automatic t_enable_clear;
    logic [15:0] h;
    con_write(3, 16'h0100);
    con_read(2, h); check("R3 en readback", h, 16'h0010);
    check("R4 irq one cycle later", irq, 0);
    @(negedge clk); check("R4 irq high", irq, 1);
    con_write(2, 16'h1000);
    con_read(0, h); check("R2 cleared", h, 0);
    @(negedge clk); check("R4 irq drops", irq, 0);
    con_write(3, 16'h0300);
    con_read(2, h); check("R3 both bits enable", h, 16'h0010);
    con_write(3, 16'h0200);
    con_read(2, h); check("R3 disable", h, 0);
  endtask

  task automatic t_con_to_ctl;
    logic [31:0] w;
    con_write(4, 16'h1234);
    @(negedge clk);
    ctl_read(0, w); check("R5 upper half no notice", w, 0);
    con_write(5, 16'h5678);
    ctl_read(1, w); check("R5 word assembled", w, 32'h1234_5678);
    ctl_read(0, w); check("R6 flag not yet", w, 0);
    @(negedge clk);
    ctl_read(0, w); check("R6 flag bit12", w, 32'h0000_1000);
    ctl_write(0, 32'h0000_2000);
    ctl_read(0, w); check("R6 flag cleared", w, 0);
  endtask

  task automatic t_overwrite;
    logic [15:0] h; logic [31:0] w;
    ctl_write(1, 32'h1111_2222);
    ctl_write(1, 32'h3333_4444);
    con_read(4, h); check("R7 hi replaced", h, 16'h3333);
    con_read(5, h); check("R7 lo replaced", h, 16'h4444);
    con_write(5, 16'h9ABC);
    ctl_read(1, w); check("R7 con lo replaced", w, 32'h1234_9ABC);
    con_write(2, 16'h1000);
    ctl_write(0, 32'h0000_2000);
  endtask

  task automatic t_races;
    logic [15:0] h; logic [31:0] w;
    @(negedge clk);
    ctl_wr = 1; ctl_sel = 1; ctl_wdata = 32'hCAFE_0001;
    con_wr = 1; con_addr = 2; con_wdata = 16'h1000;
    @(negedge clk); ctl_wr = 0; con_wr = 0;
    con_read(0, h); check("R9 console set wins", h, 16'h0400);
    con_write(2, 16'h1000);
    @(negedge clk); con_wr = 1; con_addr = 5; con_wdata = 16'h0042;
    @(negedge clk); con_wr = 0;
    ctl_wr = 1; ctl_sel = 0; ctl_wdata = 32'h0000_2000;
    @(negedge clk); ctl_wr = 0;
    ctl_read(0, w); check("R9 controller set wins", w, 32'h0000_1000);
    ctl_write(0, 32'h0000_2000);
  endtask

  task automatic t_lock_nmi;
    logic [15:0] h;
    con_write(3, 16'h0100);
    ctl_write(1, 32'h0BAD_F00D);
    @(negedge clk); check("R4 irq before lock", irq, 1);
    unlock = 0;
    @(negedge clk); check("R8 lock drops irq", irq, 0);
    ctl_write(1, 32'h0000_0001);
    con_write(3, 16'h0100);
    unlock = 1;
    con_read(0, h); check("R8 lock clears pend", h, 0);
    con_read(2, h); check("R8 locked write ignored", h, 0);
    con_write(3, 16'h0100);
    ctl_write(1, 32'h0000_0002);
    nmi = 1;
    @(negedge clk); nmi = 0;
    con_read(0, h); check("R8 nmi clears pend", h, 0);
    con_read(2, h); check("R8 nmi clears en", h, 0);
  endtask

  task automatic t_ext;
    ext = 2'b10;
    @(negedge clk); check("R4 ext source 1", irq, 1);
    ext = 2'b01;
    @(negedge clk); check("R4 ext source 0", irq, 1);
    unlock = 0;
    @(negedge clk); check("R8 ext silenced when locked", irq, 0);
    unlock = 1; ext = 2'b00;
    @(negedge clk); @(negedge clk); check("R4 ext idle", irq, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; unlock = 1;
    @(negedge clk);
    t_ctl_to_con();
    t_enable_clear();
    t_con_to_ctl();
    t_overwrite();
    t_races();
    t_lock_nmi();
    t_ext();
    finish_run();
  end
endmodule